// File: doc/BRIEF.md
# Latched Immediate Widener

This block sits at the end of an instruction-byte queue. It takes a 32-bit value that has already been aligned, and widens an immediate field inside it. An 8-bit field can grow to 16 or 32 bits, and a 16-bit field can grow to 32 bits. The new upper bits are filled either with copies of the field's top bit or with zeros. A per-instruction flag picks signed or unsigned filling.

The value enters through an input register, which loads when `loadIn` is high. It then passes through a three-way choice for each bit in the upper three bytes: keep the incoming bit, force 0, or force 1. It leaves through an output register, which loads when `loadOut` is high. The lowest byte goes straight from the input register to the output register. Two separate fill enables cover bits 15..8 and bits 31..16, so an 8-to-16 widening leaves the top half of the word alone.

The code that decides the widening mode from the opcode lives elsewhere. This block only obeys the width codes and the signed flag it is given.

Top module: `imm_widen`

## Requirements
- R1: After reset is asserted (`rstN` low), `dataOut` reads 0 until the first `loadOut` that follows reset release.
- R2: With source code 2'b00 (8 bits), destination code 2'b10 (32 bits) and `isSigned` high, output bits 31..8 all equal input bit 7.
- R3: With source code 2'b00 and destination code 2'b01 (16 bits), output bits 15..8 are filled and output bits 31..16 equal the input bits 31..16 unchanged.
- R4: With source code 2'b01 and destination code 2'b10, output bits 31..16 are filled from input bit 15 when signed, and output bits 15..8 equal the input.
- R5: With `isSigned` low, every filled bit is 0, whatever the source's top bit.
- R6: Output bits 7..0 always equal the latched input bits 7..0, in every mode.
- R7: When the source and destination codes are equal, when the destination is narrower than the source, or when either code is 2'b11, the word passes through unchanged.
- R8: While `loadIn` is low, changes on `dataIn`, `srcSel`, `dstSel` and `isSigned` have no effect on the next result.
- R9: While `loadOut` is low, `dataOut` holds its value.
- R10: A word loaded at one rising edge (`loadIn` high) appears on `dataOut` after the next rising edge at which `loadOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 32 | Aligned word from the queue |
| srcSel | input | 2 | Source width code: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| dstSel | input | 2 | Destination width code, same encoding |
| isSigned | input | 1 | 1 = fill with the sign bit, 0 = fill with zeros |
| loadIn | input | 1 | Input register load enable |
| loadOut | input | 1 | Output register load enable |
| dataOut | output | 32 | Widened word |

## Verification
The bench feeds the edge values 0x7F, 0x80, 0x7FFF and 0x8000, plus random words, through all sixteen source/destination code pairs, both signed and unsigned. This exposes a sign tap taken from the wrong bit, for example bit 7 used for a 16-bit source. Such a design would fill 16-to-32 results from the wrong bit and get 0x8000 versus 0x0080 backwards.

Random upper halves in the 8-to-16 case catch a design that fills the whole top three bytes. The reserved and narrowing code pairs catch a decoder that fills on a partial match.

Between loads, the bench scrambles the inputs and holds the enables low. A register that loads without its enable would then show scrambled data, or a result that changes one cycle early.

// File: rtl/imm_widen_pkg.sv
package imm_widen_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int HALF_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_RSV = 2'b11
  } widthCode_e;

  typedef struct packed {
    logic fillMid;
    logic fillHi;
    logic fillVal;
  } fillStrobe_t;
endpackage

// File: rtl/imm_widen_ctrl.sv
module imm_widen_ctrl
  import imm_widen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  srcCode,
  input  logic [1:0]  dstCode,
  input  logic        signedMode,
  input  logic        bit7,
  input  logic        bit15,
  output fillStrobe_t strobe
);
  logic srcIs8, srcIs16, dstIs16, dstIs32;
  logic signTap;

  always_comb begin
    srcIs8  = (srcCode == WID_8);
    srcIs16 = (srcCode == WID_16);
    dstIs16 = (dstCode == WID_16);
    dstIs32 = (dstCode == WID_32);
    signTap = srcIs8 ? bit7 : bit15;
    strobe.fillMid = srcIs8 && (dstIs16 || dstIs32);
    strobe.fillHi  = dstIs32 && (srcIs8 || srcIs16);
    strobe.fillVal = signedMode && signTap;
  end

  // R7: equal codes never enable a fill
  p_equal_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srcCode == dstCode) |-> !(strobe.fillMid || strobe.fillHi));

  // R5: unsigned mode never forces ones
  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    !signedMode |-> !strobe.fillVal);

  // R3: a 16-bit destination leaves the top half unfilled
  p_top_untouched_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dstCode == WID_16) |-> !strobe.fillHi);
endmodule

// File: rtl/imm_widen_dp.sv
module imm_widen_dp
  import imm_widen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        srcSel,
  input  logic [1:0]        dstSel,
  input  logic              isSigned,
  input  logic              loadIn,
  input  logic              loadOut,
  input  fillStrobe_t       strobe,
  output logic [1:0]        srcCode,
  output logic [1:0]        dstCode,
  output logic              signedMode,
  output logic              bit7,
  output logic              bit15,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] inWord;
  logic [DATA_W-1:0] extWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inWord     <= '0;
      srcCode    <= WID_8;
      dstCode    <= WID_8;
      signedMode <= 1'b0;
    end else if (loadIn) begin
      inWord     <= dataIn;
      srcCode    <= srcSel;
      dstCode    <= dstSel;
      signedMode <= isSigned;
    end
  end

  assign bit7  = inWord[LANE_W-1];
  assign bit15 = inWord[HALF_W-1];

  // low byte bypasses the select entirely
  assign extWord[LANE_W-1:0] = inWord[LANE_W-1:0];

  for (genvar b = LANE_W; b < DATA_W; b++) begin : g_bitSel
    localparam bit IN_TOP = (b >= HALF_W);
    logic laneFill;
    assign laneFill   = IN_TOP ? strobe.fillHi : strobe.fillMid;
    assign extWord[b] = laneFill ? strobe.fillVal : inWord[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        dataOut <= '0;
    else if (loadOut) dataOut <= extWord;
  end

  // R9: output register holds without its enable
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !loadOut |=> $stable(dataOut));

  // R8: input register holds without its enable
  p_in_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> $stable(inWord));

  // R6: low byte copied from the latched input
  p_low_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadOut |=> (dataOut[LANE_W-1:0] == $past(inWord[LANE_W-1:0])));

  // R2: 8-to-32 signed replicates bit 7 across the upper bytes
  p_sign8_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadOut && srcCode == WID_8 && dstCode == WID_32 && signedMode)
      |=> (dataOut[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){$past(inWord[LANE_W-1])}}));
endmodule

// File: rtl/imm_widen.sv
module imm_widen
  import imm_widen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] dataIn,
  input  logic [1:0]  srcSel,
  input  logic [1:0]  dstSel,
  input  logic        isSigned,
  input  logic        loadIn,
  input  logic        loadOut,
  output logic [31:0] dataOut
);
  fillStrobe_t strobe;
  logic [1:0]  srcCode, dstCode;
  logic        signedMode, bit7, bit15;

  imm_widen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcCode    (srcCode),
    .dstCode    (dstCode),
    .signedMode (signedMode),
    .bit7       (bit7),
    .bit15      (bit15),
    .strobe     (strobe)
  );

  imm_widen_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .srcSel     (srcSel),
    .dstSel     (dstSel),
    .isSigned   (isSigned),
    .loadIn     (loadIn),
    .loadOut    (loadOut),
    .strobe     (strobe),
    .srcCode    (srcCode),
    .dstCode    (dstCode),
    .signedMode (signedMode),
    .bit7       (bit7),
    .bit15      (bit15),
    .dataOut    (dataOut)
  );
endmodule

// File: tb/test_imm_widen.sv
module test_imm_widen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] dataIn;
  logic [1:0]  srcSel, dstSel;
  logic        isSigned, loadIn, loadOut;
  logic [31:0] dataOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expQ[$];
  logic [31:0] lowQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_widen i_imm_widen (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .srcSel(srcSel), .dstSel(dstSel),
    .isSigned(isSigned), .loadIn(loadIn), .loadOut(loadOut), .dataOut(dataOut)
  );

  function automatic logic [31:0] refModel(logic [31:0] d, logic [1:0] s,
                                           logic [1:0] t, logic sg);
    logic [31:0] r;
    logic f;
    r = d;
    if (s == 2'b00 && t == 2'b01) begin
      f = sg & d[7];
      r[15:8] = {8{f}};
    end else if (s == 2'b00 && t == 2'b10) begin
      f = sg & d[7];
      r[31:8] = {24{f}};
    end else if (s == 2'b01 && t == 2'b10) begin
      f = sg & d[15];
      r[31:16] = {16{f}};
    end
    return r;
  endfunction

  function automatic string tagFor(logic [1:0] s, logic [1:0] t, logic sg);
    if (!((s == 2'b00 && (t == 2'b01 || t == 2'b10)) || (s == 2'b01 && t == 2'b10)))
      return "R7";
    if (!sg) return "R5";
    if (s == 2'b01) return "R4";
    if (t == 2'b01) return "R3";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares one cycle after each loadOut edge (R10)
  bit sawLoad = 1'b0;
  always @(negedge clk) begin
    if (sawLoad && expQ.size() > 0) begin
      logic [31:0] e, lo;
      string t;
      e  = expQ.pop_front();
      lo = lowQ.pop_front();
      t  = tagQ.pop_front();
      check({t, " (R10 timing)"}, dataOut, e);
      check("R6", {24'h0, dataOut[7:0]}, {24'h0, lo[7:0]});
    end
    sawLoad = loadOut;
  end

  task automatic runOne(logic [31:0] d, logic [1:0] s, logic [1:0] t, logic sg);
    @(posedge clk); #1;
    dataIn = d; srcSel = s; dstSel = t; isSigned = sg; loadIn = 1'b1;
    @(posedge clk); #1;
    loadIn = 1'b0;
    // R8: scramble inputs while the input register is closed
    dataIn = $urandom; srcSel = 2'(~s); dstSel = 2'(~t); isSigned = ~sg;
    loadOut = 1'b1;
    expQ.push_back(refModel(d, s, t, sg));
    lowQ.push_back(d);
    tagQ.push_back(tagFor(s, t, sg));
    @(posedge clk); #1;
    loadOut = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats[7];
    rstN = 1'b0; dataIn = 32'hDEADBEEF; srcSel = 2'b00; dstSel = 2'b10;
    isSigned = 1'b1; loadIn = 1'b1; loadOut = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", dataOut, 32'h0);
    rstN = 1'b1; loadIn = 1'b0; loadOut = 1'b0;
    @(posedge clk); #1;
    check("R1", dataOut, 32'h0);

    pats[0] = 32'h0000_007F; pats[1] = 32'hA5A5_0080;
    pats[2] = 32'h1234_7FFF; pats[3] = 32'hC3C3_8000;
    for (int i = 4; i < 7; i++) pats[i] = $urandom;

    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        for (int sg = 0; sg < 2; sg++)
          for (int p = 0; p < 7; p++)
            runOne(pats[p], 2'(s), 2'(t), 1'(sg));

    // R9: a fresh input load without loadOut leaves dataOut alone
    @(posedge clk); #1;
    begin
      logic [31:0] held;
      held = dataOut;
      dataIn = 32'h0000_0080; srcSel = 2'b00; dstSel = 2'b10; isSigned = 1'b1;
      loadIn = 1'b1;
      @(posedge clk); #1;
      loadIn = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R9", dataOut, held);
      // R8/R10: the held input now emerges once loadOut pulses
      dataIn = 32'h1111_1111;
      loadOut = 1'b1;
      @(posedge clk); #1;
      loadOut = 1'b0;
      check("R8", dataOut, 32'hFFFF_FF80);
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule